// File: doc/BRIEF.md
# Dual-Channel Phase-Count Pulse Generator

This block drives two pulse outputs. Each output's waveform is set by two 16-bit numbers: how many prescaled ticks it stays high, and how many ticks it then stays low. The period is therefore the sum of the two counts. Each channel has its own 7-bit prescaler and picks one of four source tick inputs. In a single-clock design these inputs are clock-enable strobes.

Software programs the block through a small word-addressed register port. There are two count words, one per channel, and one control word that both channels share. For each channel the control word carries the source choice, the prescale value, a clock enable and an output enable. Counts written while a channel runs are taken in only when the current period ends, so a running waveform never shows a clipped or merged phase.

Top module: `dual_pwm`

## Requirements
- R1: The word at byte offset 0x0 (channel A counts), 0x4 (channel B counts) and 0x8 (control) reads back the last value written to it. Every other offset reads zero. An access whose address bits 1:0 are nonzero writes nothing and reads zero. After reset every word reads zero.
- R2: In a count word, bits 31:16 are the high count H and bits 15:0 are the low count L. When a channel is enabled, its output starts high for H ticks, then stays low for L ticks, and repeats with a period of H+L ticks.
- R3: The prescale field N is at control bits 14:8 for A and 22:16 for B. One channel tick occurs every N+1 pulses of the selected source.
- R4: The source field S is at control bits 5:4 for A and 7:6 for B. It selects input src_tick[S]. While the selected input stays 0, the waveform does not advance.
- R5: The output enables are control bit 0 (A) and bit 1 (B). The clock enables are bit 15 (A) and bit 23 (B). When either enable of a channel is 0, that output is low and its counters are reset. Enabling the channel again restarts it at the start of the high phase.
- R6: L=0 with H nonzero gives a constant high output. H=0 gives a constant low output, and this includes H=L=0.
- R7: Counts written while a channel runs take effect only at the next period boundary.
- R8: The two channels run independently. A disabled channel stays low while the other runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_addr | input | 4 | Byte address of the register access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| src_tick | input | 4 | Source tick strobes, one per selectable source |
| pwm_out | output | 2 | Pulse outputs, bit 0 = channel A, bit 1 = channel B |

## Verification
A register write takes effect at the clock edge that samples the strobe. The read port is combinational, so the new value is visible for the rest of that cycle. An enable written at edge E changes the output right after E. With prescale N the k-th tick falls on edge E+k(N+1), so the output holds each value for whole multiples of N+1 cycles after E. The bench drives every input at falling edges and compares the outputs at falling edges. Its expected value for cycle n after the enabling edge is computed in closed form from H, L, N and the source choice. Count updates made while a channel runs are checked against the period that was already in progress.

// File: rtl/dual_pwm_pkg.sv
package dual_pwm_pkg;
    localparam int NUM_CH   = 2;
    localparam int CNT_W    = 16;
    localparam int DIV_W    = 7;
    localparam int NUM_SRC  = 4;
    localparam int SEL_W    = $clog2(NUM_SRC);
    localparam int DATA_W   = 32;
    // control word layout: output enable at bit ch, source select at
    // SEL_BASE + SEL_W*ch, prescale at DIV_BASE + DIV_STEP*ch, clock
    // enable right above the prescale field
    localparam int SEL_BASE = 4;
    localparam int DIV_BASE = 8;
    localparam int DIV_STEP = 8;

    typedef struct packed {
        logic [CNT_W-1:0] hi;
        logic [CNT_W-1:0] lo;
        logic [DIV_W-1:0] div;
        logic [SEL_W-1:0] sel;
        logic             clk_en;
        logic             out_en;
    } chan_cfg_t;
endpackage

// File: rtl/dual_pwm_regs.sv
module dual_pwm_regs
    import dual_pwm_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [DATA_W-1:0]     wdata,
    output logic [DATA_W-1:0]     rdata,
    output chan_cfg_t [NUM_CH-1:0] cfg
);
    localparam int IDX_W = ADDR_W - 2;
    localparam logic [IDX_W-1:0] CTRL_IDX = IDX_W'(NUM_CH);

    typedef struct packed {
        logic [NUM_CH-1:0][DATA_W-1:0] cnt;
        logic [DATA_W-1:0]             ctrl;
    } regs_t;

    regs_t r_d, r_q;

    logic [IDX_W-1:0] widx;
    logic             aligned;

    assign widx    = addr[ADDR_W-1:2];
    assign aligned = (addr[1:0] == 2'b00);

    always_comb begin
        r_d = r_q;
        if (wr_en && aligned) begin
            for (int c = 0; c < NUM_CH; c++) begin
                if (widx == IDX_W'(c)) r_d.cnt[c] = wdata;
            end
            if (widx == CTRL_IDX) r_d.ctrl = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        rdata = '0;
        if (aligned) begin
            for (int c = 0; c < NUM_CH; c++) begin
                if (widx == IDX_W'(c)) rdata = r_q.cnt[c];
            end
            if (widx == CTRL_IDX) rdata = r_q.ctrl;
        end
    end

    always_comb begin
        for (int c = 0; c < NUM_CH; c++) begin
            cfg[c].hi     = r_q.cnt[c][CNT_W +: CNT_W];
            cfg[c].lo     = r_q.cnt[c][0 +: CNT_W];
            cfg[c].out_en = r_q.ctrl[c];
            cfg[c].sel    = r_q.ctrl[SEL_BASE + SEL_W*c +: SEL_W];
            cfg[c].div    = r_q.ctrl[DIV_BASE + DIV_STEP*c +: DIV_W];
            cfg[c].clk_en = r_q.ctrl[DIV_BASE + DIV_STEP*c + DIV_W];
        end
    end
endmodule

// File: rtl/dual_pwm_presc.sv
module dual_pwm_presc #(
    parameter int NUM_SRC = 4,
    parameter int SEL_W   = 2,
    parameter int DIV_W   = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic [NUM_SRC-1:0] src_tick,
    input  logic [SEL_W-1:0]   sel,
    input  logic [DIV_W-1:0]   div,
    output logic               tick
);
    typedef struct packed {
        logic [DIV_W-1:0] pcnt;
    } presc_t;

    presc_t s_d, s_q;
    logic   hit;

    assign hit  = src_tick[sel];
    // >= keeps a lowered prescale from wrapping the counter
    assign tick = run && hit && (s_q.pcnt >= div);

    always_comb begin
        s_d = s_q;
        if (!run) begin
            s_d.pcnt = '0;
        end else if (hit) begin
            s_d.pcnt = tick ? '0 : s_q.pcnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/dual_pwm_phase.sv
module dual_pwm_phase #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic [CNT_W-1:0] hi_in,
    input  logic [CNT_W-1:0] lo_in,
    output logic             pwm,
    output logic [CNT_W-1:0] hi_sh,
    output logic [CNT_W-1:0] lo_sh
);
    typedef struct packed {
        logic             in_high;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] hi;
        logic [CNT_W-1:0] lo;
    } phase_t;

    phase_t           s_d, s_q;
    logic [CNT_W-1:0] cnt_inc;

    assign cnt_inc = s_q.cnt + 1'b1;

    always_comb begin
        s_d = s_q;
        if (!run) begin
            s_d.in_high = 1'b1;
            s_d.cnt     = '0;
            s_d.hi      = hi_in;
            s_d.lo      = lo_in;
        end else if (tick) begin
            if (s_q.in_high && (s_q.hi != '0) && (cnt_inc < s_q.hi)) begin
                s_d.cnt = cnt_inc;
            end else if (s_q.in_high && (s_q.lo != '0)) begin
                s_d.in_high = 1'b0;
                s_d.cnt     = '0;
            end else if (!s_q.in_high && (cnt_inc < s_q.lo)) begin
                s_d.cnt = cnt_inc;
            end else begin
                // period boundary: take in the programmed counts
                s_d.in_high = 1'b1;
                s_d.cnt     = '0;
                s_d.hi      = hi_in;
                s_d.lo      = lo_in;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '{in_high: 1'b1, default: '0};
        else        s_q <= s_d;
    end

    assign pwm   = run && s_q.in_high && (s_q.hi != '0);
    assign hi_sh = s_q.hi;
    assign lo_sh = s_q.lo;
endmodule

// File: rtl/dual_pwm.sv
module dual_pwm
    import dual_pwm_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    input  logic [NUM_SRC-1:0] src_tick,
    output logic [NUM_CH-1:0]  pwm_out
);
    chan_cfg_t [NUM_CH-1:0]             cfg;
    logic [NUM_CH-1:0]                  run;
    logic [NUM_CH-1:0]                  tick;
    logic [NUM_CH-1:0][SEL_W-1:0]       sel;
    logic [NUM_CH-1:0][CNT_W-1:0]       hi_sh;
    logic [NUM_CH-1:0][CNT_W-1:0]       lo_sh;

    dual_pwm_regs #(.ADDR_W(ADDR_W)) regs_i (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (reg_wr),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .rdata (reg_rdata),
        .cfg   (cfg)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        assign run[g] = cfg[g].clk_en && cfg[g].out_en;
        assign sel[g] = cfg[g].sel;

        dual_pwm_presc #(
            .NUM_SRC (NUM_SRC),
            .SEL_W   (SEL_W),
            .DIV_W   (DIV_W)
        ) presc_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .run      (run[g]),
            .src_tick (src_tick),
            .sel      (cfg[g].sel),
            .div      (cfg[g].div),
            .tick     (tick[g])
        );

        dual_pwm_phase #(.CNT_W(CNT_W)) phase_i (
            .clk   (clk),
            .rst_n (rst_n),
            .run   (run[g]),
            .tick  (tick[g]),
            .hi_in (cfg[g].hi),
            .lo_in (cfg[g].lo),
            .pwm   (pwm_out[g]),
            .hi_sh (hi_sh[g]),
            .lo_sh (lo_sh[g])
        );
    end
endmodule

// File: rtl/dual_pwm_chk.sv
module dual_pwm_chk
    import dual_pwm_pkg::*;
(
    input logic                        clk,
    input logic                        rst_n,
    input logic [NUM_SRC-1:0]          src_tick,
    input logic [NUM_CH-1:0]           pwm_out,
    input logic [NUM_CH-1:0]           run,
    input logic [NUM_CH-1:0]           tick,
    input logic [NUM_CH-1:0][SEL_W-1:0] sel,
    input logic [NUM_CH-1:0][CNT_W-1:0] hi_sh,
    input logic [NUM_CH-1:0][CNT_W-1:0] lo_sh
);
    for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
        a_r5_off_low: assert property (@(posedge clk) disable iff (!rst_n)
            !run[g] |-> !pwm_out[g]);

        a_r3_tick_needs_src: assert property (@(posedge clk) disable iff (!rst_n)
            tick[g] |-> src_tick[sel[g]]);

        a_r6_zero_high_low: assert property (@(posedge clk) disable iff (!rst_n)
            (hi_sh[g] == '0) |-> !pwm_out[g]);

        a_r6_zero_low_high: assert property (@(posedge clk) disable iff (!rst_n)
            (run[g] && hi_sh[g] != '0 && lo_sh[g] == '0) |-> pwm_out[g]);

        a_r7_counts_held: assert property (@(posedge clk) disable iff (!rst_n)
            (run[g] && $past(run[g]) && !$past(tick[g]))
                |-> ($stable(hi_sh[g]) && $stable(lo_sh[g])));
    end
endmodule

bind dual_pwm dual_pwm_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .src_tick (src_tick),
    .pwm_out  (pwm_out),
    .run      (run),
    .tick     (tick),
    .sel      (sel),
    .hi_sh    (hi_sh),
    .lo_sh    (lo_sh)
);

// File: tb/dual_pwm_tb_top.sv
module dual_pwm_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    // sources 0, 1, 3 pulse every cycle; source 2 never pulses
    logic [3:0]  src_tick = 4'b1011;
    logic [1:0]  pwm_out;

    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    dual_pwm dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .src_tick  (src_tick),
        .pwm_out   (pwm_out)
    );

    typedef struct packed {
        logic        ch;
        logic [1:0]  sel;
        logic [6:0]  div;
        logic [15:0] hi;
        logic [15:0] lo;
    } vec_t;

    localparam int NVEC = 9;
    localparam vec_t VECS [NVEC] = '{
        '{ch:1'b0, sel:2'd0, div:7'd0, hi:16'd3, lo:16'd2},
        '{ch:1'b0, sel:2'd3, div:7'd2, hi:16'd2, lo:16'd3},
        '{ch:1'b1, sel:2'd0, div:7'd1, hi:16'd4, lo:16'd1},
        '{ch:1'b1, sel:2'd1, div:7'd0, hi:16'd1, lo:16'd5},
        '{ch:1'b0, sel:2'd0, div:7'd0, hi:16'd5, lo:16'd0},
        '{ch:1'b1, sel:2'd0, div:7'd3, hi:16'd0, lo:16'd4},
        '{ch:1'b0, sel:2'd2, div:7'd0, hi:16'd2, lo:16'd2},
        '{ch:1'b1, sel:2'd0, div:7'd0, hi:16'd0, lo:16'd0},
        '{ch:1'b1, sel:2'd3, div:7'd4, hi:16'd3, lo:16'd2}
    };

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_chk(input logic [3:0] a, input logic [31:0] exp, input string tag);
        reg_addr = a;
        #1;
        chk(reg_rdata, exp, tag);
    endtask

    function automatic logic [31:0] ctrl_word(input logic ch, input logic [1:0] sel,
                                              input logic [6:0] div);
        logic [31:0] w = '0;
        w[ch]               = 1'b1;
        w[15 + 8*ch]        = 1'b1;
        w[4 + 2*ch +: 2]    = sel;
        w[8 + 8*ch +: 7]    = div;
        return w;
    endfunction

    function automatic logic model(input vec_t v, input int n);
        int t, pos;
        if (v.hi == 0) return 1'b0;
        if (v.lo == 0) return 1'b1;
        if (v.sel == 2'd2) return 1'b1;
        t   = n / (int'(v.div) + 1);
        pos = t % (int'(v.hi) + int'(v.lo));
        return pos < int'(v.hi);
    endfunction

    initial begin
        #600000;
        mismatched++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 R5: reset state
        rd_chk(4'h0, 32'h0, "R1 reset A counts");
        rd_chk(4'h4, 32'h0, "R1 reset B counts");
        rd_chk(4'h8, 32'h0, "R1 reset control");
        chk({30'd0, pwm_out}, 32'h0, "R5 reset outputs low");

        // R1: readback, unmapped and misaligned accesses
        wr(4'h0, 32'h1234_5678);
        wr(4'h4, 32'h9ABC_DEF0);
        wr(4'h8, 32'h00CD_00F0);
        rd_chk(4'h0, 32'h1234_5678, "R1 readback A");
        rd_chk(4'h4, 32'h9ABC_DEF0, "R1 readback B");
        rd_chk(4'h8, 32'h00CD_00F0, "R1 readback control");
        rd_chk(4'hC, 32'h0, "R1 unmapped reads zero");
        rd_chk(4'h1, 32'h0, "R1 misaligned reads zero");
        wr(4'h2, 32'hFFFF_FFFF);
        rd_chk(4'h0, 32'h1234_5678, "R1 misaligned write ignored");
        chk({30'd0, pwm_out}, 32'h0, "R5 output enables clear keeps low");

        // table of waveforms (R2 R3 R4 R6 R8)
        for (int i = 0; i < NVEC; i++) begin
            vec_t v = VECS[i];
            wr(4'h8, 32'h0);
            wr({1'b0, v.ch, 2'b00}, {v.hi, v.lo});
            wr(4'h8, ctrl_word(v.ch, v.sel, v.div));
            for (int n = 0; n < 40; n++) begin
                chk({31'd0, pwm_out[v.ch]}, {31'd0, model(v, n)},
                    $sformatf("R2 R3 R4 R6 vec%0d cycle%0d", i, n));
                chk({31'd0, pwm_out[~v.ch]}, 32'h0,
                    $sformatf("R8 idle channel vec%0d cycle%0d", i, n));
                @(negedge clk);
            end
        end

        // R5: clock enable drop forces low; re-enable restarts high phase
        wr(4'h8, 32'h0);
        wr(4'h0, {16'd5, 16'd5});
        wr(4'h8, ctrl_word(1'b0, 2'd0, 7'd0));
        repeat (7) @(negedge clk);
        chk({31'd0, pwm_out[0]}, 32'h0, "R2 low phase reached");
        wr(4'h8, 32'h0000_0001);
        for (int n = 0; n < 10; n++) begin
            chk({31'd0, pwm_out[0]}, 32'h0, "R5 clock enable off holds low");
            @(negedge clk);
        end
        wr(4'h8, ctrl_word(1'b0, 2'd0, 7'd0));
        for (int n = 0; n < 10; n++) begin
            chk({31'd0, pwm_out[0]}, {31'd0, n < 5}, "R5 restart at high phase");
            @(negedge clk);
        end

        // R7: update while running lands at the period boundary
        wr(4'h8, 32'h0);
        wr(4'h0, {16'd3, 16'd3});
        wr(4'h8, ctrl_word(1'b0, 2'd0, 7'd0));
        chk({31'd0, pwm_out[0]}, 32'h1, "R7 first cycle high");
        wr(4'h0, {16'd1, 16'd1});
        for (int n = 2; n < 14; n++) begin
            logic e;
            e = (n < 6) ? (n < 3) : ((n - 6) % 2 == 0);
            chk({31'd0, pwm_out[0]}, {31'd0, e}, $sformatf("R7 cycle%0d", n));
            @(negedge clk);
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule